// File: doc/BRIEF.md
# H-Bridge Gate Control with Qualified Fault Latch

This block is the digital control core of a two-leg H-bridge motor driver. Two asynchronous command pins select one of four bridge states (drive one way, drive the other way, brake through both low sides, or all off). The block turns that choice into four gate-enable outputs, one each for the high and low transistor of each leg. Before any high or low side is enabled, it checks the conducting-status feedback of the opposite transistor in the same leg, so a leg never shorts the supply.

Fault indications come in as synchronous digital status bits: short to ground, low-side overcurrent, over-temperature and supply undervoltage. Two leg-level reads are used for an open-load test. The short, overcurrent and open-load conditions must hold for a qualification window of about 40 µs, counted in clock cycles from `CLK_HZ`, before they latch. Over-temperature latches at once. A latched fault removes every gate enable and drives the active-low error flag through an open-drain pull-down enable. Only a change on a command pin clears the latch. Undervoltage removes the gates while it lasts but does not set the flag.

Top module: `hbridge_ctrl`

## Requirements
- R1: With no fault, no undervoltage and no conducting feedback, the synchronised command {cmd_a,cmd_b} sets gate_en (bit0 leg-1 high, bit1 leg-1 low, bit2 leg-2 high, bit3 leg-2 low) as follows: 00 gives 4'b1001, 01 gives 4'b0110, 10 gives 4'b1010, 11 gives 4'b0000.
- R2: A high-side enable is low whenever the low-side feedback of the same leg is set, and a low-side enable is low whenever the high-side feedback of the same leg is set. cond_fb uses the same bit order as gate_en.
- R3: A short-to-ground or overcurrent input must hold for QUAL_CYC consecutive cycles (QUAL_CYC = round(CLK_HZ × QUAL_NS / 1e9)) before err_pd rises and gate_en goes to zero. A shorter pulse leaves no trace, and the count restarts from zero.
- R4: flt_thermal clears gate_en and raises err_pd in the same cycle. The flag stays latched after flt_thermal falls.
- R5: While supply_low is high, gate_en is zero. supply_low does not raise err_pd.
- R6: Once latched, err_pd stays high, with gate_en zero, until either command pin changes. The change clears the latch and applies the new command.
- R7: The open-load condition (leg1_hi high and leg2_hi low) is evaluated only in command 11 and qualifies like R3. In any other command it is ignored.
- R8: If a qualifying fault is still present when a command change clears the latch, a fresh full QUAL_CYC window must pass before err_pd rises again.
- R9: A command pin change reaches gate_en after exactly two rising clock edges.
- R10: During reset, gate_en is zero and err_pd is low.
- R11: The high and low enables of one leg are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_a | input | 1 | Asynchronous command pin A (upper command bit) |
| cmd_b | input | 1 | Asynchronous command pin B (lower command bit) |
| cond_fb | input | 4 | Transistor conducting feedback, same bit order as gate_en |
| flt_short | input | 1 | High side shorted to ground |
| flt_ovc | input | 1 | Low-side overcurrent |
| flt_thermal | input | 1 | Over-temperature, immediate |
| supply_low | input | 1 | Supply undervoltage |
| leg1_hi | input | 1 | Leg-1 output reads high |
| leg2_hi | input | 1 | Leg-2 output reads high |
| gate_en | output | 4 | Gate enables {leg2 low, leg2 high, leg1 low, leg1 high} |
| err_pd | output | 1 | Error flag pull-down enable (1 = flag driven low) |

## Verification
The assertions assume that the status inputs (fault bits, feedback, leg reads) are synchronous to clk and change only between edges. Only the command pins may be asynchronous. They also assume that the over-temperature input reaches the outputs combinationally within the cycle. The stimulus drives every input on the falling edge. It holds each command for at least four cycles, so that a change is always seen through the synchroniser. It samples gate_en and err_pd one nanosecond after a falling edge, after counting the edges on the path from pin to output.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    CMD_FWD   = 2'b00,
    CMD_REV   = 2'b01,
    CMD_BRAKE = 2'b10,
    CMD_OFF   = 2'b11
  } hb_cmd_e;

  localparam int G_HI1 = 0;
  localparam int G_LO1 = 1;
  localparam int G_HI2 = 2;
  localparam int G_LO2 = 3;
  localparam int NUM_SW = 4;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          W      = 2,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        always_comb stg_d = d;
      end else begin : g_next
        always_comb stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode
  import hb_pkg::*;
(
  input  hb_cmd_e             cmd,
  input  logic [NUM_SW-1:0]   cond_fb,
  input  logic                kill,
  output logic [NUM_SW-1:0]   gate_en
);
  logic [NUM_SW-1:0] want;
  logic [NUM_SW-1:0] blocked;

  always_comb begin
    want = '0;
    unique case (cmd)
      CMD_FWD:   begin want[G_HI1] = 1'b1; want[G_LO2] = 1'b1; end
      CMD_REV:   begin want[G_LO1] = 1'b1; want[G_HI2] = 1'b1; end
      CMD_BRAKE: begin want[G_LO1] = 1'b1; want[G_LO2] = 1'b1; end
      default:   want = '0;
    endcase
  end

  // each switch is blocked by its partner in the same leg
  genvar l;
  generate
    for (l = 0; l < NUM_SW / 2; l++) begin : g_leg
      always_comb begin
        blocked[2*l]     = cond_fb[2*l+1];
        blocked[2*l + 1] = cond_fb[2*l];
      end
    end
  endgenerate

  always_comb gate_en = kill ? '0 : (want & ~blocked);
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch #(
  parameter int QUAL_CYC = 8000,
  localparam int CNT_W = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_cond,
  input  logic instant,
  input  logic cmd_change,
  output logic latched
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lat_q, lat_d;
  logic             cnt_done;

  assign cnt_done = qual_cond && (cnt_q == CNT_W'(QUAL_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (cmd_change || !qual_cond) cnt_d = '0;
    else if (!cnt_done)           cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (cmd_change) lat_d = instant;
    else            lat_d = lat_q | instant | cnt_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  assign latched = lat_q;
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int QUAL_NS     = 40_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_a,
  input  logic        cmd_b,
  input  logic [3:0]  cond_fb,
  input  logic        flt_short,
  input  logic        flt_ovc,
  input  logic        flt_thermal,
  input  logic        supply_low,
  input  logic        leg1_hi,
  input  logic        leg2_hi,
  output logic [3:0]  gate_en,
  output logic        err_pd
);
  localparam longint QUAL_LL  = (longint'(CLK_HZ) * longint'(QUAL_NS) + 64'd500_000_000) / 64'd1_000_000_000;
  localparam int     QUAL_CYC = (QUAL_LL < 1) ? 1 : int'(QUAL_LL);

  logic [1:0] cmd_s, cmd_prev;
  logic       cmd_change;
  logic       open_load;
  logic       qual_cond;
  logic       latched;
  logic       kill;

  hb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cmd_a, cmd_b}),
    .q     (cmd_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_prev <= 2'b11;
    else        cmd_prev <= cmd_s;
  end

  assign cmd_change = (cmd_s != cmd_prev);
  assign open_load  = (hb_cmd_e'(cmd_s) == CMD_OFF) && leg1_hi && !leg2_hi;
  assign qual_cond  = flt_short || flt_ovc || open_load;

  hb_fault_latch #(.QUAL_CYC(QUAL_CYC)) u_flt (
    .clk        (clk),
    .rst_n      (rst_n),
    .qual_cond  (qual_cond),
    .instant    (flt_thermal),
    .cmd_change (cmd_change),
    .latched    (latched)
  );

  assign kill   = latched || flt_thermal || supply_low || !rst_n;
  assign err_pd = (latched || flt_thermal) && rst_n;

  hb_cmd_decode u_dec (
    .cmd     (hb_cmd_e'(cmd_s)),
    .cond_fb (cond_fb),
    .kill    (kill),
    .gate_en (gate_en)
  );
endmodule

// File: rtl/hb_ctrl_checker.sv
module hb_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] gate_en,
  input logic [3:0] cond_fb,
  input logic       flt_thermal,
  input logic       supply_low,
  input logic       err_pd
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_quiet: assert (gate_en == 4'b0000 && !err_pd);
    end
  end

  a_r2_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en[0] && cond_fb[1]) && !(gate_en[1] && cond_fb[0]) &&
    !(gate_en[2] && cond_fb[3]) && !(gate_en[3] && cond_fb[2]));

  a_r11_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en[0] && gate_en[1]) && !(gate_en[2] && gate_en[3]));

  a_r4_thermal_now: assert property (@(posedge clk) disable iff (!rst_n)
    flt_thermal |-> (gate_en == 4'b0000) && err_pd);

  a_r5_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> gate_en == 4'b0000);

  a_r6_flag_kills: assert property (@(posedge clk) disable iff (!rst_n)
    err_pd |-> gate_en == 4'b0000);
endmodule

bind hbridge_ctrl hb_ctrl_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_en     (gate_en),
  .cond_fb     (cond_fb),
  .flt_thermal (flt_thermal),
  .supply_low  (supply_low),
  .err_pd      (err_pd)
);

// File: tb/hbridge_ctrl_test.sv
`timescale 1ns/1ps
module hbridge_ctrl_test;
  localparam int QUAL = 40;  // 1 MHz nominal x 40 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_a = 1'b1, cmd_b = 1'b1;
  logic [3:0] cond_fb = 4'b0;
  logic flt_short = 0, flt_ovc = 0, flt_thermal = 0, supply_low = 0;
  logic leg1_hi = 0, leg2_hi = 0;
  logic [3:0] gate_en;
  logic err_pd;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  hbridge_ctrl #(.CLK_HZ(1_000_000), .QUAL_NS(40_000)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b), .cond_fb(cond_fb),
    .flt_short(flt_short), .flt_ovc(flt_ovc), .flt_thermal(flt_thermal),
    .supply_low(supply_low), .leg1_hi(leg1_hi), .leg2_hi(leg2_hi),
    .gate_en(gate_en), .err_pd(err_pd)
  );

  function automatic logic [3:0] exp_gate(input logic [1:0] c);
    case (c)
      2'b00:   return 4'b1001;
      2'b01:   return 4'b0110;
      2'b10:   return 4'b1010;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // advance n rising edges, return 1 ns after the following falling edge
  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic drive_cmd(input logic [1:0] c);
    @(negedge clk);
    {cmd_a, cmd_b} = c;
    edges(4);
  endtask

  task automatic t_reset;
    #1;
    check("R10 gate", {4'b0, gate_en}, 8'h00);
    check("R10 err", {7'b0, err_pd}, 8'h00);
    edges(3);
    rst_n = 1'b1;
    edges(4);
    check("R1 off after reset", {4'b0, gate_en}, 8'h00);
  endtask

  task automatic t_decode;
    for (int c = 0; c < 4; c++) begin
      drive_cmd(2'(c));
      check("R1 decode", {4'b0, gate_en}, {4'b0, exp_gate(2'(c))});
      check("R11 leg", {7'b0, (gate_en[0] & gate_en[1]) | (gate_en[2] & gate_en[3])}, 8'h00);
    end
    // R9 latency: from 11 to 00
    @(negedge clk);
    {cmd_a, cmd_b} = 2'b00;
    edges(1);
    check("R9 one edge", {4'b0, gate_en}, 8'h00);
    edges(1);
    check("R9 two edges", {4'b0, gate_en}, 8'h09);
    edges(2);
  endtask

  task automatic t_interlock;
    drive_cmd(2'b00);
    cond_fb = 4'b0010;  // leg-1 low conducting
    #1;
    check("R2 hi1 blocked", {4'b0, gate_en}, 8'h08);
    cond_fb = 4'b0110;  // also leg-2 high conducting
    #1;
    check("R2 lo2 blocked", {4'b0, gate_en}, 8'h00);
    cond_fb = 4'b0;
    #1;
    check("R2 restored", {4'b0, gate_en}, 8'h09);
  endtask

  task automatic t_qual;
    drive_cmd(2'b01);
    @(negedge clk); flt_short = 1;
    edges(QUAL - 1);
    check("R3 short pulse", {7'b0, err_pd}, 8'h00);
    flt_short = 0;
    edges(1);
    flt_short = 1;
    edges(QUAL - 1);
    check("R3 restarted count", {7'b0, err_pd}, 8'h00);
    edges(1);
    check("R3 latched", {7'b0, err_pd}, 8'h01);
    check("R3 gates off", {4'b0, gate_en}, 8'h00);
    edges(50);
    check("R6 held", {7'b0, err_pd}, 8'h01);
    flt_short = 0;
    edges(10);
    check("R6 held w/o fault", {7'b0, err_pd}, 8'h01);
    drive_cmd(2'b00);
    check("R6 cleared", {7'b0, err_pd}, 8'h00);
    check("R6 new cmd", {4'b0, gate_en}, 8'h09);
  endtask

  task automatic t_refresh;
    @(negedge clk); flt_ovc = 1;
    edges(QUAL);
    check("R3 ovc latched", {7'b0, err_pd}, 8'h01);
    @(negedge clk);
    {cmd_a, cmd_b} = 2'b10;
    edges(2);
    edges(QUAL);       // edge 3 clears, then QUAL-1 counted edges
    check("R8 not yet", {7'b0, err_pd}, 8'h00);
    check("R8 brake applied", {4'b0, gate_en}, 8'h0A);
    edges(1);
    check("R8 relatched", {7'b0, err_pd}, 8'h01);
    flt_ovc = 0;
    drive_cmd(2'b00);
    check("R6 cleared ovc", {7'b0, err_pd}, 8'h00);
  endtask

  task automatic t_thermal;
    drive_cmd(2'b01);
    @(negedge clk); flt_thermal = 1;
    #1;
    check("R4 gates now", {4'b0, gate_en}, 8'h00);
    check("R4 flag now", {7'b0, err_pd}, 8'h01);
    edges(3);
    flt_thermal = 0;
    edges(5);
    check("R4 stays latched", {7'b0, err_pd}, 8'h01);
    drive_cmd(2'b10);
    check("R6 thermal cleared", {7'b0, err_pd}, 8'h00);
  endtask

  task automatic t_uv;
    drive_cmd(2'b00);
    @(negedge clk); supply_low = 1;
    edges(QUAL + 10);
    check("R5 gates off", {4'b0, gate_en}, 8'h00);
    check("R5 no flag", {7'b0, err_pd}, 8'h00);
    supply_low = 0;
    #1;
    check("R5 restored", {4'b0, gate_en}, 8'h09);
  endtask

  task automatic t_openload;
    drive_cmd(2'b00);
    @(negedge clk); leg1_hi = 1; leg2_hi = 0;
    edges(2 * QUAL);
    check("R7 ignored when driving", {7'b0, err_pd}, 8'h00);
    @(negedge clk); leg1_hi = 1; leg2_hi = 1;
    {cmd_a, cmd_b} = 2'b11;
    edges(2 * QUAL);
    check("R7 loaded no flag", {7'b0, err_pd}, 8'h00);
    leg2_hi = 0;
    edges(QUAL - 1);
    check("R7 before window", {7'b0, err_pd}, 8'h00);
    edges(1);
    check("R7 open load", {7'b0, err_pd}, 8'h01);
    leg1_hi = 0;
    drive_cmd(2'b01);
    check("R6 open cleared", {7'b0, err_pd}, 8'h00);
  endtask

  initial begin
    #400_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_interlock();
    t_qual();
    t_refresh();
    t_thermal();
    t_uv();
    t_openload();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule